// File: doc/BRIEF.md
# SUBLEQ Single-Instruction Processor Core

This block is a small 16-bit processor with one instruction: subtract, then branch if the result is less than or equal to zero. Every instruction is three words long and starts at the program counter. The words are operand address `a`, operand address `b` and branch target `c`. The core computes `M[b] = M[b] - M[a]` and writes the result back to `M[b]`. If the signed result is zero or negative, execution continues at `c`. Otherwise it continues at the word after `c`.

A fixed control sequence drives the core, one cycle per step, and instructions never overlap. The datapath holds three registers: the program counter, an address latch and an accumulator. An adder does the arithmetic: it can negate its bus input, and it can either add the accumulator or ignore it. Multiplexers stand in for a shared internal data bus.

The memory port is a single synchronous RAM port with a combinational read path. Read data is valid in the same cycle as the address and is captured at the end of that cycle. A write commits at the clock edge that ends the write cycle. Two inputs, a run enable and an interrupt request, suspend the core in a hold state, but only between instructions.

Top module: `subleq_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the core sits in the first fetch step: `state_dbg` is 0, `mem_addr` equals `RESET_PC`, and `mem_we` and `hold` are low.
- R2: Each executed instruction leaves `M[b]` equal to the old `M[b]` minus `M[a]`, wrapped modulo 2^DATA_W.
- R3: After an instruction, the next fetch address is `c` when the result, read as a signed number, is zero or negative. Otherwise it is the instruction address plus 3.
- R4: State codes include 0 for the first fetch step, 1 for the operand-load step that follows it, and 8 for hold. Measured from the cycle in code 0 to the next entry into code 0 or 8, an instruction lasts 6 cycles when the branch is not taken and 7 cycles when it is taken.
- R5: Every instruction asserts `mem_we` for exactly one cycle. The write goes to the same address as the read just before it, which is address `b`.
- R6: With `run` low, the core enters hold (`state_dbg` 8, `hold` high) once the current instruction completes. It performs no memory write while held.
- R7: A high `irq` suspends the core the same way, only at an instruction boundary, so instruction lengths are unchanged. The core leaves hold for code 0 in the cycle after `irq` is low and `run` is high.
- R8: The program counter only ever steps by +1, or is loaded with a branch target.
- R9: An instruction with `a` equal to `b` clears that word and always branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run enable; low requests hold at the next boundary |
| irq | input | 1 | Suspend request, honoured between instructions |
| mem_rdata | input | DATA_W | Read data for the current `mem_addr` |
| mem_addr | output | DATA_W | Memory word address |
| mem_wdata | output | DATA_W | Write data (accumulator) |
| mem_we | output | 1 | Write enable, one cycle per instruction |
| hold | output | 1 | High while suspended |
| state_dbg | output | 4 | Current control step code |

## Verification
The bench builds the core with a 16-bit data width, 4-bit adder slices and a reset address of 0. The program and data occupy a 64-word window. At 16 bits, operand values such as 0x8000 and 0x7FFF exercise the signed branch decision at its wrap points, and every subtraction carries across all four adder slices. Random programs with random suspend pulses, plus a directed countdown and wrap sequence, are checked instruction by instruction against an interpreter in the bench.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

  typedef enum logic [3:0] {
    ST_FETCH_A = 4'd0,
    ST_LOAD_A  = 4'd1,
    ST_FETCH_B = 4'd2,
    ST_SUB_B   = 4'd3,
    ST_WRITE_B = 4'd4,
    ST_SKIP_C  = 4'd5,
    ST_FETCH_C = 4'd6,
    ST_JUMP    = 4'd7,
    ST_HOLD    = 4'd8
  } state_e;

  typedef enum logic [1:0] {
    BUS_RAM  = 2'd0,
    BUS_DREG = 2'd1,
    BUS_AREG = 2'd2
  } bus_src_e;

  typedef struct packed {
    logic     pc_inc;
    logic     pc_load;
    logic     addr_load;
    logic     data_load;
    logic     alu_keep;
    logic     alu_neg;
    logic     addr_from_pc;
    logic     mem_we;
    logic     flag_load;
    bus_src_e bus_src;
  } uop_t;

endpackage

// File: rtl/subleq_alu.sv
module subleq_alu #(
  parameter int DW    = 16,
  parameter int SLICE = 4
) (
  input  logic [DW-1:0] bus_val,
  input  logic [DW-1:0] acc,
  input  logic          keep,
  input  logic          neg,
  output logic [DW-1:0] res,
  output logic          leq
);
  localparam int NSL = DW / SLICE;

  logic [DW-1:0]  opa;
  logic [DW-1:0]  opb;
  logic [NSL-1:0] cin;

  assign opa    = keep ? acc : '0;
  assign opb    = neg ? ~bus_val : bus_val;
  assign cin[0] = neg;

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    if (s < NSL - 1) begin : g_mid
      logic [SLICE:0] sum;
      assign sum = {1'b0, opa[s*SLICE +: SLICE]} + {1'b0, opb[s*SLICE +: SLICE]}
                 + {{SLICE{1'b0}}, cin[s]};
      assign res[s*SLICE +: SLICE] = sum[SLICE-1:0];
      assign cin[s+1] = sum[SLICE];
    end else begin : g_top
      assign res[s*SLICE +: SLICE] = opa[s*SLICE +: SLICE] + opb[s*SLICE +: SLICE]
                                   + {{(SLICE-1){1'b0}}, cin[s]};
    end
  end

  assign leq = res[DW-1] | (res == '0);

endmodule

// File: rtl/subleq_ctrl.sv
module subleq_ctrl
  import subleq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  logic   irq,
  input  logic   leq_q,
  output state_e state,
  output uop_t   uop
);
  state_e nxt;
  logic   stall;

  assign stall = irq | ~run;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH_A;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FETCH_A: nxt = stall ? ST_HOLD : ST_LOAD_A;
      ST_LOAD_A:  nxt = ST_FETCH_B;
      ST_FETCH_B: nxt = ST_SUB_B;
      ST_SUB_B:   nxt = ST_WRITE_B;
      ST_WRITE_B: nxt = leq_q ? ST_FETCH_C : ST_SKIP_C;
      ST_FETCH_C: nxt = ST_JUMP;
      ST_SKIP_C,
      ST_JUMP,
      ST_HOLD:    nxt = stall ? ST_HOLD : ST_FETCH_A;
      default:    nxt = ST_FETCH_A;
    endcase
  end

  always_comb begin
    uop = '0;
    uop.bus_src = BUS_RAM;
    unique case (state)
      ST_FETCH_A: if (!stall) begin
        uop.addr_from_pc = 1'b1;
        uop.addr_load    = 1'b1;
        uop.pc_inc       = 1'b1;
      end
      ST_LOAD_A: begin
        uop.data_load = 1'b1;
        uop.alu_neg   = 1'b1;
      end
      ST_FETCH_B: begin
        uop.addr_from_pc = 1'b1;
        uop.addr_load    = 1'b1;
        uop.pc_inc       = 1'b1;
      end
      ST_SUB_B: begin
        uop.data_load = 1'b1;
        uop.alu_keep  = 1'b1;
        uop.flag_load = 1'b1;
      end
      ST_WRITE_B: begin
        uop.bus_src = BUS_DREG;
        uop.mem_we  = 1'b1;
      end
      ST_SKIP_C:  uop.pc_inc = 1'b1;
      ST_FETCH_C: begin
        uop.addr_from_pc = 1'b1;
        uop.addr_load    = 1'b1;
      end
      ST_JUMP: begin
        uop.bus_src = BUS_AREG;
        uop.pc_load = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/subleq_datapath.sv
module subleq_datapath
  import subleq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          SLICE    = 4,
  parameter logic [DW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  uop_t          uop,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [DW-1:0] pc_q,
  output logic          leq_q
);
  logic [DW-1:0] areg_q;
  logic [DW-1:0] dreg_q;
  logic [DW-1:0] bus;
  logic [DW-1:0] alu_res;
  logic          alu_leq;

  always_comb begin
    unique case (uop.bus_src)
      BUS_DREG: bus = dreg_q;
      BUS_AREG: bus = areg_q;
      default:  bus = mem_rdata;
    endcase
  end

  subleq_alu #(.DW(DW), .SLICE(SLICE)) u_alu (
    .bus_val (bus),
    .acc     (dreg_q),
    .keep    (uop.alu_keep),
    .neg     (uop.alu_neg),
    .res     (alu_res),
    .leq     (alu_leq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      areg_q <= '0;
      dreg_q <= '0;
      leq_q  <= 1'b0;
    end else begin
      if (uop.pc_load)        pc_q <= bus;
      else if (uop.pc_inc)    pc_q <= pc_q + DW'(1);
      if (uop.addr_load)      areg_q <= bus;
      if (uop.data_load)      dreg_q <= alu_res;
      if (uop.flag_load)      leq_q  <= alu_leq;
    end
  end

  assign mem_addr  = uop.addr_from_pc ? pc_q : areg_q;
  assign mem_wdata = dreg_q;
  assign mem_we    = uop.mem_we;

endmodule

// File: rtl/subleq_core.sv
module subleq_core
  import subleq_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              ALU_SLICE = 4,
  parameter logic [DATA_W-1:0] RESET_PC  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              irq,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              hold,
  output logic [3:0]        state_dbg
);
  state_e            state;
  uop_t              uop;
  logic              leq_q;
  logic [DATA_W-1:0] pc_q;

  subleq_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .irq   (irq),
    .leq_q (leq_q),
    .state (state),
    .uop   (uop)
  );

  subleq_datapath #(.DW(DATA_W), .SLICE(ALU_SLICE), .RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .uop       (uop),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .pc_q      (pc_q),
    .leq_q     (leq_q)
  );

  assign state_dbg = state;
  assign hold      = (state == ST_HOLD);

endmodule

// File: rtl/subleq_core_chk.sv
module subleq_core_chk
  import subleq_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] mem_addr,
  input logic          mem_we,
  input logic          hold,
  input logic [3:0]    state_dbg,
  input logic [DW-1:0] pc_q
);
  // R5
  wr_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == $past(mem_addr)));

  // R5
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R7
  hold_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (state_dbg == 4'(ST_HOLD) && $past(state_dbg) != 4'(ST_HOLD)) |->
      ($past(state_dbg) == 4'(ST_FETCH_A) || $past(state_dbg) == 4'(ST_SKIP_C) ||
       $past(state_dbg) == 4'(ST_JUMP)));

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold |-> !mem_we);

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + DW'(1) || $past(state_dbg) == 4'(ST_JUMP)));

  // R4
  branch_fork_chk: assert property (@(posedge clk) disable iff (rst)
    (state_dbg == 4'(ST_WRITE_B)) |=> (state_dbg == 4'(ST_SKIP_C) || state_dbg == 4'(ST_FETCH_C)));

endmodule

bind subleq_core subleq_core_chk #(.DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .hold      (hold),
  .state_dbg (state_dbg),
  .pc_q      (pc_q)
);

// File: tb/tb_subleq_core.sv
`timescale 1ns/1ps
module tb_subleq_core;
  localparam int DW = 16;
  localparam int MW = 6;
  localparam int MD = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          irq = 1'b0;
  logic [DW-1:0] mem_rdata, mem_addr, mem_wdata;
  logic          mem_we, hold;
  logic [3:0]    state_dbg;

  int checks = 0;
  int fails  = 0;
  int n_instr = 0;

  logic [DW-1:0] img  [MD];
  logic [DW-1:0] ram  [MD];
  logic [DW-1:0] refm [MD];

  always #2.5 clk = ~clk;

  subleq_core #(.DATA_W(DW), .ALU_SLICE(4), .RESET_PC('0)) dut (
    .clk(clk), .rst(rst), .run(run), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .hold(hold), .state_dbg(state_dbg)
  );

  assign mem_rdata = ram[mem_addr[MW-1:0]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MD; i++) ram[i] <= img[i];
    end else if (mem_we) begin
      ram[mem_addr[MW-1:0]] <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference interpreter state, advanced in lockstep
  logic [DW-1:0] ref_pc, fa_addr;
  logic [3:0]    prev_st;
  bit            active, prev_stall;
  int            cyc, start_cyc, exp_len, wr_cnt;
  logic [MW-1:0] b_idx;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < MD; i++) refm[i] = img[i];
      ref_pc = '0; active = 0; prev_st = 4'd0; wr_cnt = 0; prev_stall = 0;
    end else begin
      logic [DW-1:0] a, b, c, r;
      if (mem_we) wr_cnt++;
      if (state_dbg == 4'd0) fa_addr = mem_addr;
      if ((state_dbg == 4'd0 || state_dbg == 4'd8) && prev_st != 4'd0 && prev_st != 4'd8 && active) begin
        check(cyc - start_cyc == exp_len, "R4 instruction length", cyc - start_cyc, exp_len);
        check(wr_cnt == 1, "R5 one write per instruction", wr_cnt, 1);
        check(ram[b_idx] == refm[b_idx], "R2 result at b", ram[b_idx], refm[b_idx]);
        active = 0;
      end
      if (prev_st == 4'd8)
        check(state_dbg == (prev_stall ? 4'd8 : 4'd0), "R7 hold exit", state_dbg, prev_stall ? 8 : 0);
      if (state_dbg == 4'd8) check(!mem_we && hold, "R6 quiet hold", {mem_we, hold}, 1);
      if (state_dbg == 4'd1 && prev_st == 4'd0) begin
        check(fa_addr == ref_pc, "R3 R8 fetch address", fa_addr, ref_pc);
        a = refm[ref_pc[MW-1:0]];
        b = refm[MW'(ref_pc + 1)];
        c = refm[MW'(ref_pc + 2)];
        r = refm[b[MW-1:0]] - refm[a[MW-1:0]];
        refm[b[MW-1:0]] = r;
        b_idx = b[MW-1:0];
        if ($signed(r) <= 0) begin ref_pc = c; exp_len = 7; end
        else begin ref_pc = ref_pc + 3; exp_len = 6; end
        start_cyc = cyc - 1;
        wr_cnt = 0;
        active = 1;
        n_instr++;
      end
      prev_stall = irq | ~run;
      prev_st = state_dbg;
    end
  end

  task automatic do_reset();
    rst = 1'b1; run = 1'b0; irq = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1
    check(state_dbg == 4'd0 && mem_addr == '0 && !mem_we && !hold, "R1 reset state",
          {state_dbg, mem_addr}, 0);
    @(posedge clk); #1;
    rst = 1'b0; run = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_instr, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // directed: countdown, a==b clear, signed wrap
    for (int i = 0; i < MD; i++) img[i] = '0;
    img[0] = 16'd50; img[1] = 16'd51; img[2] = 16'd6;
    img[3] = 16'd52; img[4] = 16'd52; img[5] = 16'd0;
    img[6] = 16'd50; img[7] = 16'd54; img[8] = 16'd0;
    img[9] = 16'd52; img[10] = 16'd52; img[11] = 16'd9;
    img[50] = 16'd1; img[51] = 16'd5; img[52] = 16'd7; img[54] = 16'h8000;
    do_reset();
    repeat (150) @(posedge clk);
    // R6: drop run, state must settle in hold with memory frozen
    #1 run = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(state_dbg == 4'd8 && hold, "R6 held after run low", state_dbg, 8);
    check(ram[51] == 16'd0, "R2 countdown reached zero", ram[51], 0);
    check(ram[52] == 16'd0, "R9 a==b clears", ram[52], 0);
    check(ram[54] == 16'h7FFF, "R2 R3 wrap result not taken", ram[54], 16'h7FFF);
    @(posedge clk); #1 run = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(ram[54] == 16'h7FFF, "R3 halt loop stable", ram[54], 16'h7FFF);

    // random programs with random suspend requests
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < MD; i++) img[i] = '0;
      for (int k = 0; k < 12; k++) begin
        img[3*k]   = DW'(40 + $urandom % 24);
        img[3*k+1] = DW'(40 + $urandom % 24);
        img[3*k+2] = DW'(3 * ($urandom % 12));
      end
      img[36] = 16'd40; img[37] = 16'd40; img[38] = 16'd0;
      for (int i = 40; i < MD; i++) begin
        case ($urandom % 6)
          0: img[i] = 16'h8000;
          1: img[i] = 16'h7FFF;
          2: img[i] = DW'($urandom % 4);
          default: img[i] = DW'($urandom);
        endcase
      end
      do_reset();
      for (int k = 0; k < 6000; k++) begin
        int r;
        @(posedge clk); #1;
        r = int'($urandom % 100);
        if (r < 2) irq = 1'b1;
        else if (r < 12) irq = 1'b0;
        if (r == 50) run = 1'b0;
        else if (r > 85) run = 1'b1;
      end
      irq = 1'b0; run = 1'b1;
      repeat (20) @(posedge clk);
    end
    @(negedge clk);
    check(n_instr > 1000, "R2 instructions executed", n_instr, 1000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule